// File: doc/BRIEF.md
# Clock Gate Bank with Set, Clear and Status Words

This block switches a bank of up to 32 input clocks on and off from a small register port. In its default form, software turns gates on by writing ones to a set word and turns them off by writing ones to a clear word. Zero bits in either write leave their gates alone, so two agents can control different gates without a read-modify-write sequence. A read-only status word shows which gates are currently enabled.

A build-time option replaces the set and clear words with a single control word that is loaded directly. In that form, each gate can be given inverted polarity, so that a stored 0 turns it on.

Each gate enable passes through a short synchronizer clocked by that gate's own source clock. It then drives a cell with a latch and an AND gate. The latch is transparent while the source clock is low, so an enable change cannot cut a high phase short.

Top module: `gate_bank`

Register layout, one word per step of 4 in `regAddr`:
- 0x0 is the set word, or the control word in direct mode.
- 0x4 is the clear word.
- 0x8 is the status word.

Bit n of every word belongs to gate n. A write takes effect at the rising `clk` edge on which `regWr` is high. Reads are combinational from `regAddr`.

## Requirements
- R1: After reset every gate is disabled, the status word (0x8) reads zero and every gated output stays low.
- R2: In separated mode, a write to 0x0 enables each gate whose data bit is 1; gates whose data bit is 0 keep their state.
- R3: In separated mode, a write to 0x4 disables each gate whose data bit is 1; gates whose data bit is 0 keep their state.
- R4: Reading 0x8 returns bit n = 1 exactly when gate n is enabled, starting from the cycle after the write that changed it.
- R5: In separated mode, reads of 0x0, of 0x4 and of any unmapped address return zero.
- R6: Writes to 0x8, to unmapped addresses and to addresses that are not multiples of 4 change no gate.
- R7: Status bits at and above NUM_GATES read zero, and write data bits at those positions have no effect.
- R8: An enabled gate passes its source clock: the output is high during the source high phase and low during the low phase. A disabled gate holds its output low. A change becomes visible within SYNC_STAGES+1 source clock rising edges.
- R9: In direct mode (SEPARATED=0), a write to 0x0 loads the control word. Gate n is enabled when control bit n differs from POL_INV bit n. Reading 0x0 returns the control word, and writes to 0x4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register port clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Write strobe |
| regAddr | input | 4 | Byte address of the word |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data for `regAddr` |
| gateClkIn | input | NUM_GATES | Source clocks, one per gate |
| gateClkOut | output | NUM_GATES | Gated clocks |

## Verification
The bench builds two copies of the block.

The first copy is an eight-gate bank in separated mode with two synchronizer stages. Its narrow width lets all-ones writes show that bits above the gate count are dropped (R7). The short synchronizer keeps the clock-output checks within a few source cycles.

The second copy is a four-gate bank in direct mode with polarity mask 0101. Mixed polarity shows both the stored-0-enables and stored-1-enables cases in one control word. It also shows that the clear word is inert in that mode.

// File: rtl/gate_bank_pkg.sv
package gate_bank_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFF_SET  = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_CLR  = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_STAT = 4'h8;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_CTRL,
    RD_STAT
  } rdSel_e;

  typedef struct packed {
    logic setStb;
    logic clrStb;
    logic loadStb;
  } gateStb_t;
endpackage

// File: rtl/gate_bank_ctrl.sv
module gate_bank_ctrl
  import gate_bank_pkg::*;
#(
  parameter bit SEPARATED = 1'b1
) (
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  output gateStb_t          stb,
  output rdSel_e            rdSel
);

  always_comb begin
    stb   = '0;
    rdSel = RD_NONE;
    case (regAddr)
      OFF_SET: begin
        if (SEPARATED) begin
          stb.setStb = regWr;
        end else begin
          stb.loadStb = regWr;
          rdSel       = RD_CTRL;
        end
      end
      OFF_CLR: begin
        if (SEPARATED) stb.clrStb = regWr;
      end
      OFF_STAT: rdSel = RD_STAT;
      default: ;
    endcase
  end

endmodule

// File: rtl/gate_bank_dp.sv
module gate_bank_dp
  import gate_bank_pkg::*;
#(
  parameter int                   NUM_GATES = 32,
  parameter int                   DATA_W    = 32,
  parameter bit                   SEPARATED = 1'b1,
  parameter logic [NUM_GATES-1:0] POL_INV   = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gateStb_t             stb,
  input  rdSel_e               rdSel,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_GATES-1:0] enState
);

  logic [NUM_GATES-1:0] wdGates;
  logic [NUM_GATES-1:0] ctrlWord;

  assign wdGates = wrData[NUM_GATES-1:0];

  if (SEPARATED) begin : g_sep
    logic [NUM_GATES-1:0] enReg;
    logic [NUM_GATES-1:0] setMask;
    logic [NUM_GATES-1:0] clrMask;

    assign setMask = stb.setStb ? wdGates : '0;
    assign clrMask = stb.clrStb ? wdGates : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enReg <= '0;
      end else if (stb.setStb || stb.clrStb) begin
        enReg <= (enReg | setMask) & ~clrMask;
      end
    end

    assign enState  = enReg;
    assign ctrlWord = '0;
  end else begin : g_dir
    logic [NUM_GATES-1:0] ctrlReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctrlReg <= POL_INV;
      end else if (stb.loadStb) begin
        ctrlReg <= wdGates;
      end
    end

    assign enState  = ctrlReg ^ POL_INV;
    assign ctrlWord = ctrlReg;
  end

  always_comb begin
    rdData = '0;
    case (rdSel)
      RD_CTRL: rdData[NUM_GATES-1:0] = ctrlWord;
      RD_STAT: rdData[NUM_GATES-1:0] = enState;
      default: ;
    endcase
  end

endmodule

// File: rtl/gate_cell.sv
module gate_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clkIn,
  input  logic rstN,
  input  logic en,
  output logic clkOut
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   enLat;

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      syncQ[0] <= en;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end

  // Open only during the low phase, so the AND below sees a steady enable
  // for the whole high phase.
  always_latch begin
    if (!clkIn) enLat = syncQ[SYNC_STAGES-1];
  end

  assign clkOut = clkIn & enLat;

endmodule

// File: rtl/gate_bank.sv
module gate_bank
  import gate_bank_pkg::*;
#(
  parameter int                   NUM_GATES   = 32,
  parameter int                   DATA_W      = 32,
  parameter int                   SYNC_STAGES = 2,
  parameter bit                   SEPARATED   = 1'b1,
  parameter logic [NUM_GATES-1:0] POL_INV     = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWr,
  input  logic [3:0]           regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic [NUM_GATES-1:0] gateClkIn,
  output logic [NUM_GATES-1:0] gateClkOut
);

  gateStb_t             stb;
  rdSel_e               rdSel;
  logic [NUM_GATES-1:0] enState;

  gate_bank_ctrl #(
    .SEPARATED(SEPARATED)
  ) u_ctrl (
    .regWr  (regWr),
    .regAddr(regAddr),
    .stb    (stb),
    .rdSel  (rdSel)
  );

  gate_bank_dp #(
    .NUM_GATES(NUM_GATES),
    .DATA_W   (DATA_W),
    .SEPARATED(SEPARATED),
    .POL_INV  (POL_INV)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .rdSel  (rdSel),
    .wrData (regWrData),
    .rdData (regRdData),
    .enState(enState)
  );

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_cell
    gate_cell #(
      .SYNC_STAGES(SYNC_STAGES)
    ) u_cell (
      .clkIn (gateClkIn[g]),
      .rstN  (rstN),
      .en    (enState[g]),
      .clkOut(gateClkOut[g])
    );
  end

endmodule

// File: rtl/gate_bank_chk.sv
module gate_bank_chk
  import gate_bank_pkg::*;
#(
  parameter int NUM_GATES = 32,
  parameter int DATA_W    = 32,
  parameter bit SEPARATED = 1'b1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWr,
  input logic [3:0]           regAddr,
  input logic [DATA_W-1:0]    regWrData,
  input logic [DATA_W-1:0]    regRdData,
  input logic [NUM_GATES-1:0] enState
);

  logic [NUM_GATES-1:0] wd;
  assign wd = regWrData[NUM_GATES-1:0];

  AST_RESET_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> enState == '0); // R1

  AST_STATUS_MATCHES: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == OFF_STAT |-> regRdData[NUM_GATES-1:0] == enState); // R4

  AST_STATUS_WRITE_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == OFF_STAT) |=> $stable(enState)); // R6

  if (SEPARATED) begin : g_sep
    AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rstN)
      (regWr && regAddr == OFF_SET) |=> (enState & $past(wd)) == $past(wd)); // R2

    AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rstN)
      (regWr && regAddr == OFF_CLR) |=> (enState & $past(wd)) == '0); // R3

    AST_ZERO_BITS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (regWr && (regAddr == OFF_SET || regAddr == OFF_CLR))
        |=> ((enState ^ $past(enState)) & ~$past(wd)) == '0); // R2

    AST_STROBE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (regAddr == OFF_SET || regAddr == OFF_CLR) |-> regRdData == '0); // R5
  end else begin : g_dir
    AST_CLR_INERT_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
      (regWr && regAddr == OFF_CLR) |=> $stable(enState)); // R9
  end

endmodule

bind gate_bank gate_bank_chk #(
  .NUM_GATES(NUM_GATES),
  .DATA_W   (DATA_W),
  .SEPARATED(SEPARATED)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWr    (regWr),
  .regAddr  (regAddr),
  .regWrData(regWrData),
  .regRdData(regRdData),
  .enState  (enState)
);

// File: tb/gate_bank_test.sv
module gate_bank_test;

  logic        clk = 1'b0;
  logic        srcClk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrA = 1'b0;
  logic        regWrB = 1'b0;
  logic [3:0]  regAddr = 4'h0;
  logic [31:0] regWrData = '0;
  logic [31:0] rdDataA;
  logic [31:0] rdDataB;
  logic [7:0]  gateOutA;
  logic [3:0]  gateOutB;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;
  always #15 srcClk = ~srcClk;

  gate_bank #(
    .NUM_GATES(8), .DATA_W(32), .SYNC_STAGES(2), .SEPARATED(1'b1), .POL_INV(8'h00)
  ) uut (
    .clk(clk), .rstN(rstN), .regWr(regWrA), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rdDataA),
    .gateClkIn({8{srcClk}}), .gateClkOut(gateOutA)
  );

  gate_bank #(
    .NUM_GATES(4), .DATA_W(32), .SYNC_STAGES(2), .SEPARATED(1'b0), .POL_INV(4'b0101)
  ) uutDirect (
    .clk(clk), .rstN(rstN), .regWr(regWrB), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rdDataB),
    .gateClkIn({4{srcClk}}), .gateClkOut(gateOutB)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrA(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrA = 1'b1;
    @(negedge clk);
    regWrA = 1'b0;
  endtask

  task automatic wrB(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrB = 1'b1;
    @(negedge clk);
    regWrB = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] dA, output logic [31:0] dB);
    @(negedge clk);
    regAddr = a;
    #2;
    dA = rdDataA;
    dB = rdDataB;
  endtask

  // Source high phase shows the enable mask; low phase must be all zero.
  task automatic checkGates(input string req, input logic [7:0] expA, input logic [3:0] expB);
    repeat (5) @(posedge srcClk);
    #5;
    check(req, {24'h0, gateOutA}, {24'h0, expA});
    check(req, {28'h0, gateOutB}, {28'h0, expB});
    @(negedge srcClk);
    #5;
    check(req, {24'h0, gateOutA}, 32'h0);
    check(req, {28'h0, gateOutB}, 32'h0);
  endtask

  task automatic testReset();
    logic [31:0] a, b;
    rd(4'h8, a, b);
    check("R1 status A", a, 32'h0);
    check("R1 status B", b, 32'h0);
    checkGates("R1 outputs", 8'h00, 4'h0);
  endtask

  task automatic testSet();
    logic [31:0] a, b;
    wrA(4'h0, 32'h05);
    rd(4'h8, a, b);
    check("R2 R4 set 05", a, 32'h05);
    checkGates("R8 gates 05", 8'h05, 4'h0);
    wrA(4'h0, 32'h10);
    rd(4'h8, a, b);
    check("R2 zero bits kept", a, 32'h15);
    checkGates("R8 gates 15", 8'h15, 4'h0);
  endtask

  task automatic testClear();
    logic [31:0] a, b;
    wrA(4'h4, 32'h04);
    rd(4'h8, a, b);
    check("R3 clear 04", a, 32'h11);
    wrA(4'h4, 32'h01);
    rd(4'h8, a, b);
    check("R3 clear 01", a, 32'h10);
    checkGates("R8 after clear", 8'h10, 4'h0);
  endtask

  task automatic testReadZero();
    logic [31:0] a, b;
    rd(4'h0, a, b);
    check("R5 read set word", a, 32'h0);
    rd(4'h4, a, b);
    check("R5 read clear word", a, 32'h0);
    rd(4'hC, a, b);
    check("R5 read unmapped", a, 32'h0);
  endtask

  task automatic testIgnored();
    logic [31:0] a, b;
    wrA(4'h8, 32'hFF);
    rd(4'h8, a, b);
    check("R6 status write", a, 32'h10);
    wrA(4'hC, 32'hFF);
    wrA(4'h1, 32'hFF);
    wrA(4'h6, 32'hFF);
    rd(4'h8, a, b);
    check("R6 unmapped and misaligned", a, 32'h10);
  endtask

  task automatic testWidth();
    logic [31:0] a, b;
    wrA(4'h0, 32'hFFFF_FFFF);
    rd(4'h8, a, b);
    check("R7 upper bits zero", a, 32'hFF);
    checkGates("R8 all on", 8'hFF, 4'h0);
    wrA(4'h4, 32'hFFFF_FF00);
    rd(4'h8, a, b);
    check("R7 upper clear bits inert", a, 32'hFF);
    wrA(4'h4, 32'hFFFF_FFFF);
    rd(4'h8, a, b);
    check("R3 clear all", a, 32'h0);
    checkGates("R8 all off", 8'h00, 4'h0);
  endtask

  task automatic testDirect();
    logic [31:0] a, b;
    wrB(4'h0, 32'h5);
    rd(4'h8, a, b);
    check("R9 ctrl equals polarity", b, 32'h0);
    rd(4'h0, a, b);
    check("R9 ctrl readback", b, 32'h5);
    wrB(4'h0, 32'h0);
    rd(4'h8, a, b);
    check("R9 inverted bits on", b, 32'h5);
    checkGates("R9 R8 direct gates", 8'h00, 4'h5);
    wrB(4'h0, 32'hA);
    rd(4'h8, a, b);
    check("R9 all on", b, 32'hF);
    wrB(4'h4, 32'hF);
    rd(4'h8, a, b);
    check("R9 clear word inert", b, 32'hF);
    rd(4'h0, a, b);
    check("R9 ctrl kept", b, 32'hA);
    checkGates("R9 R8 direct all", 8'h00, 4'hF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSet();
    testClear();
    testReadZero();
    testIgnored();
    testWidth();
    testDirect();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule